// File: doc/BRIEF.md
# Microcoded Accumulator Processor

This block is a compact 16-bit processor built around one accumulator. Each instruction names at most one memory word. The upper byte of every instruction word selects the operation. The lower byte gives a memory address, which is either the operand location or a branch target. A fixed set of registers carries data between memory and the arithmetic unit: program counter, instruction register, address register, data buffer, operand register and accumulator. A small state sequencer steps these transfers over several clocks per instruction.

Program and data share one memory of 256 words of 16 bits, held inside the block. A side write port fills it while the processor is held in reset. A combinational read port lets the memory be inspected at any time, and the accumulator is visible on its own output. Once the program executes its stop instruction, the processor raises a stopped flag and stays idle until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While rst_n is low at a rising clock edge, the accumulator and program counter are cleared to zero and halted is low. After release, execution starts at address 0x00.
- R2: An instruction word carries the opcode in bits [15:8] and the address field in bits [7:0]. The opcodes are 0x01 add, 0x02 subtract, 0x03 and, 0x04 or, 0x05 not, 0x06 shift right, 0x07 shift left, 0x08 multiply, 0x09 divide, 0x0A jump if non-negative, 0x0B jump, 0x0C halt, 0x0D store and 0x0E load.
- R3: Every instruction begins with the same three-clock fetch: address from PC, memory read, then decode with PC+1. An operand-reading instruction takes six clocks in total. Halt is reached three clocks after the preceding instruction ends.
- R4: Add, subtract, and and or combine the accumulator with the word at the address field. The result goes to the accumulator, and sums and differences wrap modulo 2^16.
- R5: Not writes the bitwise complement of the addressed word into the accumulator. Load copies the addressed word into the accumulator.
- R6: Shift right and shift left move the accumulator by one bit, filling with zero. They read no memory operand.
- R7: Multiply keeps the low 16 bits of the unsigned product. Divide gives the unsigned integer quotient of accumulator by operand, and division by zero yields 0xFFFF.
- R8: Store writes the accumulator into the addressed word and leaves the accumulator unchanged.
- R9: Jump loads the address field into PC. Jump-if-non-negative does the same when accumulator bit 15 is 0, zero included. Otherwise execution continues with the next word.
- R10: After halt, halted stays high and no further instruction runs, so memory, PC and accumulator hold until reset.
- R11: Opcodes outside 0x01 to 0x0E act as no-operations, and execution continues with the next word.
- R12: When load_en is high at a rising edge, load_data is written to memory at load_addr. dbg_data always shows the word at dbg_addr, and acc_out always shows the accumulator.
- R13: A count-down loop that adds 100, 99, ..., 1 into a memory word leaves 5050 there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Preload write enable |
| load_addr | input | 8 | Preload write address |
| load_data | input | 16 | Preload write data |
| dbg_addr | input | 8 | Inspection read address |
| dbg_data | output | 16 | Memory word at dbg_addr |
| acc_out | output | 16 | Current accumulator value |
| halted | output | 1 | High once halt has executed |

## Verification
Most internal faults reach the ports only indirectly. A wrong register transfer, a wrong ALU selection or a mis-sequenced state corrupts the accumulator, and that value lands in memory at the next store. A misrouted branch instead changes which marker words get written. The delay is one instruction, which is four to six clocks. A broken fetch or decode also shifts the clock on which halted rises, so the bench times the halt edge exactly. It then reads the stored results and markers through the inspection port.

// File: rtl/acc_cpu_pkg.sv
// Shared constants and types for the accumulator processor.
// Assumes an 8-bit opcode in the top byte of every instruction word.
package acc_cpu_pkg;
    localparam int OP_W = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 8'h01,
        OP_SUB    = 8'h02,
        OP_AND    = 8'h03,
        OP_OR     = 8'h04,
        OP_NOT    = 8'h05,
        OP_SHR    = 8'h06,
        OP_SHL    = 8'h07,
        OP_MUL    = 8'h08,
        OP_DIV    = 8'h09,
        OP_JGEZ   = 8'h0A,
        OP_JMP    = 8'h0B,
        OP_HALT   = 8'h0C,
        OP_STORE  = 8'h0D,
        OP_LOAD   = 8'h0E
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR,
        ST_FETCH_READ,
        ST_DECODE,
        ST_OPER_READ,
        ST_OPER_LATCH,
        ST_EXECUTE,
        ST_STORE_BUF,
        ST_STORE_WRITE,
        ST_BRANCH,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mbr_from_mem;
        logic decode;
        logic br_from_mbr;
        logic acc_from_alu;
        logic mbr_from_acc;
        logic mem_write;
        logic pc_load;
    } ctrl_t;
endpackage

// File: rtl/acc_alu.sv
// Combinational arithmetic/logic unit of the accumulator processor.
// Assumes a = accumulator, b = operand register; op is the latched opcode.
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    logic [2*W-1:0] prod;

    // Full-width product; only the low half is kept.
    always_comb prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    // Select the result for the current opcode.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOT:  y = ~b;
            OP_SHR:  y = a >> 1;
            OP_SHL:  y = a << 1;
            OP_MUL:  y = prod[W-1:0];
            OP_DIV:  y = (b == '0) ? '1 : (a / b);
            OP_LOAD: y = b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/acc_cpu_mem.sv
// Unified program/data memory with a preload port, a processor port and an
// inspection port. Writes are synchronous; reads are combinational. The
// preload port wins when both ports write in the same cycle.
module acc_cpu_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] dbg_addr,
    output logic [DATA_W-1:0] dbg_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Single write per clock, preload first.
    always_ff @(posedge clk) begin
        if (ext_we)
            cells[ext_addr] <= ext_wdata;
        else if (cpu_we)
            cells[cpu_addr] <= cpu_wdata;
    end

    // Asynchronous read ports.
    always_comb cpu_rdata = cells[cpu_addr];
    always_comb dbg_rdata = cells[dbg_addr];
endmodule

// File: rtl/acc_cpu_ctrl.sv
// State sequencer: steps each instruction through fetch, decode and its
// execution transfers, and emits one-hot register strobes. Assumes the
// decode step sees the fetched word's opcode before IR has captured it.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] fetched_op,
    input  logic [OP_W-1:0] exec_op,
    input  logic            acc_neg,
    output ctrl_t           ctl,
    output logic            halted
);
    state_e state, state_nx;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH_ADDR;
        else        state <= state_nx;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_FETCH_ADDR: state_nx = ST_FETCH_READ;
            ST_FETCH_READ: state_nx = ST_DECODE;
            ST_DECODE: begin
                case (fetched_op)
                    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOT,
                    OP_MUL, OP_DIV, OP_LOAD: state_nx = ST_OPER_READ;
                    OP_SHR, OP_SHL:          state_nx = ST_EXECUTE;
                    OP_STORE:                state_nx = ST_STORE_BUF;
                    OP_JMP, OP_JGEZ:         state_nx = ST_BRANCH;
                    OP_HALT:                 state_nx = ST_HALT;
                    default:                 state_nx = ST_FETCH_ADDR;
                endcase
            end
            ST_OPER_READ:   state_nx = ST_OPER_LATCH;
            ST_OPER_LATCH:  state_nx = ST_EXECUTE;
            ST_EXECUTE:     state_nx = ST_FETCH_ADDR;
            ST_STORE_BUF:   state_nx = ST_STORE_WRITE;
            ST_STORE_WRITE: state_nx = ST_FETCH_ADDR;
            ST_BRANCH:      state_nx = ST_FETCH_ADDR;
            ST_HALT:        state_nx = ST_HALT;
            default:        state_nx = ST_FETCH_ADDR;
        endcase
    end

    // Register-transfer strobes decoded from the state.
    always_comb begin
        ctl              = '0;
        ctl.mar_from_pc  = (state == ST_FETCH_ADDR);
        ctl.mbr_from_mem = (state == ST_FETCH_READ) || (state == ST_OPER_READ);
        ctl.decode       = (state == ST_DECODE);
        ctl.br_from_mbr  = (state == ST_OPER_LATCH);
        ctl.acc_from_alu = (state == ST_EXECUTE);
        ctl.mbr_from_acc = (state == ST_STORE_BUF);
        ctl.mem_write    = (state == ST_STORE_WRITE);
        ctl.pc_load      = (state == ST_BRANCH) &&
                           ((exec_op == OP_JMP) || ((exec_op == OP_JGEZ) && !acc_neg));
    end

    always_comb halted = (state == ST_HALT);

    // R3: fetch address step is always followed by the memory read step.
    p_fetch_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_ADDR) |=> (state == ST_FETCH_READ));

    // R10: the stopped state is never left without reset.
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT));
endmodule

// File: rtl/acc_cpu_core.sv
// Top of the accumulator processor: datapath registers (PC, IR, MAR, MBR,
// BR, ACC), sequencer, ALU and internal memory. Assumes memory is filled
// through the preload port while rst_n is low.
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_en,
    input  logic [DATA_W-OP_W-1:0] load_addr,
    input  logic [DATA_W-1:0]      load_data,
    input  logic [DATA_W-OP_W-1:0] dbg_addr,
    output logic [DATA_W-1:0]      dbg_data,
    output logic [DATA_W-1:0]      acc_out,
    output logic                   halted
);
    localparam int ADDR_W = DATA_W - OP_W;

    logic [ADDR_W-1:0] pc, mar;
    logic [OP_W-1:0]   ir;
    logic [DATA_W-1:0] mbr, br, acc;
    logic [DATA_W-1:0] mem_rdata, alu_y;
    ctrl_t             ctl;

    acc_cpu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetched_op (mbr[DATA_W-1 -: OP_W]),
        .exec_op    (ir),
        .acc_neg    (acc[DATA_W-1]),
        .ctl        (ctl),
        .halted     (halted)
    );

    acc_alu #(.W(DATA_W)) u_alu (
        .op (ir),
        .a  (acc),
        .b  (br),
        .y  (alu_y)
    );

    acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .ext_we    (load_en),
        .ext_addr  (load_addr),
        .ext_wdata (load_data),
        .cpu_we    (ctl.mem_write),
        .cpu_addr  (mar),
        .cpu_wdata (mbr),
        .cpu_rdata (mem_rdata),
        .dbg_addr  (dbg_addr),
        .dbg_rdata (dbg_data)
    );

    // Program counter: increment at decode, overwrite on a taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (ctl.decode) pc <= pc + ADDR_W'(1);
        else if (ctl.pc_load) pc <= mar;
    end

    // Address register: PC during fetch, address field at decode.
    always_ff @(posedge clk) begin
        if (!rst_n)               mar <= '0;
        else if (ctl.mar_from_pc) mar <= pc;
        else if (ctl.decode)      mar <= mbr[ADDR_W-1:0];
    end

    // Instruction register captures the opcode byte at decode.
    always_ff @(posedge clk) begin
        if (!rst_n)          ir <= '0;
        else if (ctl.decode) ir <= mbr[DATA_W-1 -: OP_W];
    end

    // Data buffer: memory read data or accumulator for a store.
    always_ff @(posedge clk) begin
        if (!rst_n)                mbr <= '0;
        else if (ctl.mbr_from_mem) mbr <= mem_rdata;
        else if (ctl.mbr_from_acc) mbr <= acc;
    end

    // Operand register and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br  <= '0;
            acc <= '0;
        end else begin
            if (ctl.br_from_mbr)  br  <= mbr;
            if (ctl.acc_from_alu) acc <= alu_y;
        end
    end

    always_comb acc_out = acc;

    // R3: every decode advances PC by exactly one.
    p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.decode |=> (pc == $past(pc) + ADDR_W'(1)));

    // R8: the processor writes memory only while a store executes.
    p_store_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_write |-> (ir == OP_STORE));

    // R9: a taken branch puts the decoded address field into PC.
    p_jump_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_load |=> (pc == $past(mar)));

    // R10: once stopped, PC and accumulator are frozen.
    p_halt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && $stable(acc) && halted));
endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] I_ADD = 8'h01, I_SUB = 8'h02, I_AND = 8'h03,
                           I_OR = 8'h04, I_NOT = 8'h05, I_SHR = 8'h06,
                           I_SHL = 8'h07, I_MUL = 8'h08, I_DIV = 8'h09,
                           I_JGEZ = 8'h0A, I_JMP = 8'h0B, I_HALT = 8'h0C,
                           I_STORE = 8'h0D, I_LOAD = 8'h0E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic [7:0]  dbg_addr = '0;
    logic [15:0] dbg_data, acc_out;
    logic        halted;
    int          checks = 0;
    int          errors = 0;

    acc_cpu_core dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .acc_out(acc_out), .halted(halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(posedge clk);
        #1 load_en = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        dbg_addr = a;
        #1 d = dbg_data;
    endtask

    task automatic ins(input logic [7:0] a, input logic [7:0] op, input logic [7:0] x);
        poke(a, {op, x});
    endtask

    // Hold reset and zero the whole memory.
    task automatic prepare();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count rising edges until halted is seen; gives up after a limit.
    task automatic run_to_halt(input string req, output int n);
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted) break;
            if (n > 20000) begin
                check({req, " halt reached"}, 16'h0, 16'h1);
                break;
            end
        end
    endtask

    // R1 R3 R10: halt timing, frozen state, reset clearing.
    task automatic t_halt_and_reset();
        int n;
        logic [15:0] d;
        prepare();
        ins(8'h00, I_LOAD, 8'h80);
        ins(8'h01, I_HALT, 8'h00);
        ins(8'h02, I_STORE, 8'h90);
        poke(8'h80, 16'h0042);
        @(negedge clk);
        check("R1 acc in reset", acc_out, 16'h0000);
        check("R1 halted in reset", {15'b0, halted}, 16'h0001 & 16'h0000);
        release_reset();
        run_to_halt("R3", n);
        check("R3 cycles to halt", 16'(n), 16'd9);
        check("R5 load value", acc_out, 16'h0042);
        repeat (30) @(negedge clk);
        check("R10 halted stays", {15'b0, halted}, 16'h0001);
        check("R10 acc frozen", acc_out, 16'h0042);
        peek(8'h90, d);
        check("R10 no execution after halt", d, 16'h0000);
        // Reset clears ACC and halted, restart from address 0.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 acc cleared", acc_out, 16'h0000);
        check("R1 halted cleared", {15'b0, halted}, 16'h0000);
        release_reset();
        run_to_halt("R1", n);
        check("R1 restart at zero cycles", 16'(n), 16'd9);
        check("R1 restart result", acc_out, 16'h0042);
    endtask

    // R2 R4 R5 R6 R7 R8 R11 R12: every data operation on one operand pair.
    task automatic t_alu(input logic [15:0] a, input logic [15:0] b);
        int n;
        int pcnt;
        logic [15:0] d;
        logic [31:0] p;
        logic [15:0] exp [11];
        logic [7:0]  mid [11];
        prepare();
        poke(8'h80, a);
        poke(8'h81, b);
        mid[0] = I_ADD; mid[1] = I_SUB; mid[2] = I_AND; mid[3] = I_OR;
        mid[4] = I_NOT; mid[5] = I_SHR; mid[6] = I_SHL; mid[7] = I_MUL;
        mid[8] = I_DIV; mid[9] = I_DIV; mid[10] = 8'h00;
        p = {16'h0, a} * {16'h0, b};
        exp[0] = a + b; exp[1] = a - b; exp[2] = a & b; exp[3] = a | b;
        exp[4] = ~b; exp[5] = a >> 1; exp[6] = a << 1; exp[7] = p[15:0];
        exp[8] = (b == 16'h0) ? 16'hFFFF : a / b;
        exp[9] = 16'hFFFF;
        exp[10] = a;
        pcnt = 0;
        for (int k = 0; k < 11; k++) begin
            ins(8'(pcnt), I_LOAD, 8'h80); pcnt++;
            if (k == 10) begin
                ins(8'(pcnt), 8'h00, 8'h81); pcnt++;
                ins(8'(pcnt), 8'hFF, 8'h81); pcnt++;
            end else begin
                ins(8'(pcnt), mid[k], (k == 9) ? 8'h82 : 8'h81); pcnt++;
            end
            ins(8'(pcnt), I_STORE, 8'(8'h90 + k)); pcnt++;
        end
        ins(8'(pcnt), I_HALT, 8'h00);
        release_reset();
        run_to_halt("R4", n);
        peek(8'h90, d);  check("R4 add wrap", d, exp[0]);
        peek(8'h91, d);  check("R4 subtract wrap", d, exp[1]);
        peek(8'h92, d);  check("R4 and", d, exp[2]);
        peek(8'h93, d);  check("R4 or", d, exp[3]);
        peek(8'h94, d);  check("R5 not", d, exp[4]);
        peek(8'h95, d);  check("R6 shift right", d, exp[5]);
        peek(8'h96, d);  check("R6 shift left", d, exp[6]);
        peek(8'h97, d);  check("R7 multiply low half", d, exp[7]);
        peek(8'h98, d);  check("R7 divide", d, exp[8]);
        peek(8'h99, d);  check("R7 divide by zero", d, exp[9]);
        peek(8'h9A, d);  check("R11 undefined opcodes", d, exp[10]);
        check("R8 acc after store", acc_out, a);
        peek(8'h81, d);  check("R12 operand intact", d, b);
        check("R2 stop reached", {15'b0, halted}, 16'h0001);
    endtask

    // R9: conditional and unconditional jumps.
    task automatic t_branch();
        int n;
        logic [15:0] d;
        prepare();
        poke(8'h80, 16'h8000);
        poke(8'h81, 16'h0007);
        poke(8'h82, 16'hDEAD);
        poke(8'h84, 16'h0055);
        ins(8'h00, I_LOAD, 8'h80);
        ins(8'h01, I_JGEZ, 8'h10);
        ins(8'h02, I_LOAD, 8'h81);
        ins(8'h03, I_JGEZ, 8'h20);
        ins(8'h04, I_STORE, 8'h90);
        ins(8'h05, I_HALT, 8'h00);
        ins(8'h10, I_LOAD, 8'h82);
        ins(8'h11, I_STORE, 8'h91);
        ins(8'h12, I_HALT, 8'h00);
        ins(8'h20, I_JMP, 8'h30);
        ins(8'h21, I_STORE, 8'h92);
        ins(8'h30, I_STORE, 8'h93);
        ins(8'h31, I_LOAD, 8'h83);
        ins(8'h32, I_JGEZ, 8'h40);
        ins(8'h33, I_HALT, 8'h00);
        ins(8'h40, I_LOAD, 8'h84);
        ins(8'h41, I_STORE, 8'h94);
        ins(8'h42, I_HALT, 8'h00);
        release_reset();
        run_to_halt("R9", n);
        peek(8'h91, d); check("R9 negative not taken", d, 16'h0000);
        peek(8'h90, d); check("R9 positive taken", d, 16'h0000);
        peek(8'h92, d); check("R9 jump skips next", d, 16'h0000);
        peek(8'h93, d); check("R9 jump target runs", d, 16'h0007);
        peek(8'h94, d); check("R9 zero counts as non-negative", d, 16'h0055);
    endtask

    // R13: count-down summation loop.
    task automatic t_sum();
        int n;
        logic [15:0] d;
        prepare();
        poke(8'h90, 16'd100);
        poke(8'h92, 16'd1);
        ins(8'h00, I_LOAD, 8'h91);
        ins(8'h01, I_ADD, 8'h90);
        ins(8'h02, I_STORE, 8'h91);
        ins(8'h03, I_LOAD, 8'h90);
        ins(8'h04, I_SUB, 8'h92);
        ins(8'h05, I_STORE, 8'h90);
        ins(8'h06, I_SUB, 8'h92);
        ins(8'h07, I_JGEZ, 8'h00);
        ins(8'h08, I_HALT, 8'h00);
        release_reset();
        run_to_halt("R13", n);
        peek(8'h91, d); check("R13 sum of 1..100", d, 16'd5050);
        peek(8'h90, d); check("R13 counter exhausted", d, 16'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_halt_and_reset();
        t_alu(16'h1234, 16'h0F0F);
        t_alu(16'h8001, 16'hFFFF);
        t_alu(16'h00C8, 16'h0007);
        t_branch();
        t_sum();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule